// File: doc/BRIEF.md
# Radix Page Table Walker

This block resolves a virtual address into a page-table entry after a translation cache has missed. It walks a four-level radix table held in memory, starting at the table root, reading one 8-byte entry per level through a single-outstanding read port. The walk ends at the first entry that is invalid or that is a leaf. The full final entry is returned, with its valid bit forced low unless that entry is also a leaf. When translation is switched off, no memory is read and an identity entry with all permissions is returned at once. This identity entry is valid only when the address lies inside memory.

The requester side is a valid/ready pair for the address and another for the result. A request is taken only while the walker is idle. The result stays on `resp_pte` with `resp_valid` high, unchanged, until `resp_ready` is seen at a clock edge. On the memory side, `rd_req_valid` and `rd_addr` hold steady until `rd_req_ready`. The read data port has no ready signal: `rd_resp_valid` is a one-cycle pulse, and it may only follow an accepted read. The translation enable, table root and memory size are plain inputs. They are sampled when a request is accepted, so a change to them applies from the next request onward.

Entry layout: bit 0 valid, bit 1 leaf, bit 2 referenced, bit 3 dirty, bits 9:4 the six permission bits, and bits 63:12 the physical page number. Pages are 4 KiB.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `resp_valid` and `rd_req_valid` are 0.
- R2: With `xlate_en` low at acceptance, no memory read is issued. The result has page number equal to the virtual page number (vaddr >> 12) in bits 63:12, leaf bit 1 set, bits 2 and 3 clear, bits 9:4 all ones, and bits 11:10 clear.
- R3: In that identity result, bit 0 is 1 exactly when `req_vaddr < mem_size`.
- R4: Reads visit level 3 down to level 0. The read for level i goes to base + 8 * vaddr[12+9i +: 9]. The first base is `pt_base` with bits 11:0 cleared.
- R5: After a valid non-leaf entry that is not at level 0, the next base is that entry's bits 47:12 followed by 12 zero bits.
- R6: The walk stops at the first entry with bit 0 clear or bit 1 set. The result is that entry, with bit 0 replaced by (bit 0 AND bit 1).
- R7: A valid non-leaf entry read at level 0 ends the walk after four reads, and the result has bit 0 clear.
- R8: If an entry address is at or above the sampled `mem_size`, that read is not issued and the result is all zeros.
- R9: At most one read is outstanding. `rd_req_valid` and `rd_addr` hold until `rd_req_ready` is seen.
- R10: `resp_valid` and `resp_pte` hold unchanged until `resp_ready` is seen. `req_ready` is low from acceptance until then.
- R11: Changes to `xlate_en`, `pt_base` and `mem_size` after acceptance do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted at this edge |
| req_vaddr | input | ADDR_W | Virtual address to resolve |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Requester takes the result |
| resp_pte | output | PTE_W | Final entry with adjusted valid bit |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory accepts the read |
| rd_addr | output | ADDR_W | Byte address of the entry to read |
| rd_resp_valid | input | 1 | Read data pulse |
| rd_resp_data | input | PTE_W | Entry read from memory |
| xlate_en | input | 1 | Translation enabled |
| pt_base | input | ADDR_W | Table root address |
| mem_size | input | ADDR_W | Bytes of physical memory |

## Verification
The bench checks the identity result at the edge of memory, one byte below and exactly at `mem_size`. A design with an off-by-one compare would flip the valid bit there. It checks a walk whose root already lies beyond memory, where a wrong design would issue a read or return stale data. It checks a chain of four non-leaf entries, where a wrong design would report valid or read a fifth level. Random walks mix early invalid entries, superpage leaves, intermediate pointers out of range, random stalls on both read handshakes and on the result, and changes to the sampled inputs during the walk. Together these expose a wrong index slice, unmasked root bits, a base taken from the wrong field, or settings that are not latched at acceptance.

// File: rtl/pt_walk_pkg.sv
`timescale 1ns/1ps
package pt_walk_pkg;
  localparam int PTE_V_BIT     = 0;
  localparam int PTE_LEAF_BIT  = 1;
  localparam int PTE_REF_BIT   = 2;
  localparam int PTE_DIRTY_BIT = 3;
  localparam int PTE_PERM_LO   = 4;
  localparam int PTE_PERM_W    = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_DONE
  } walk_state_t;
endpackage

// File: rtl/pt_entry_addr.sv
`timescale 1ns/1ps
module pt_entry_addr #(
  parameter int ADDR_W     = 48,
  parameter int LEVELS     = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int PTE_LG     = 3,
  localparam int IDX_W     = PAGE_SHIFT - PTE_LG,
  localparam int LVL_W     = $clog2(LEVELS),
  localparam int VPN_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ADDR_W-1:0] base,
  input  logic [LVL_W-1:0]  level,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              beyond
);
  logic [IDX_W-1:0] idx_per_lvl [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_per_lvl[l] = vpn[IDX_W*l +: IDX_W];
  end

  always_comb begin
    entry_addr = base + (ADDR_W'(idx_per_lvl[level]) << PTE_LG);
    beyond     = (entry_addr >= limit);
  end
endmodule

// File: rtl/pt_identity_pte.sv
`timescale 1ns/1ps
module pt_identity_pte
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int PTE_W      = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] limit,
  output logic [PTE_W-1:0]  pte
);
  always_comb begin
    pte = '0;
    pte[PAGE_SHIFT +: ADDR_W-PAGE_SHIFT] = vaddr[ADDR_W-1:PAGE_SHIFT];
    pte[PTE_PERM_LO +: PTE_PERM_W]       = '1;
    pte[PTE_LEAF_BIT]                    = 1'b1;
    pte[PTE_V_BIT]                       = (vaddr < limit);
  end
endmodule

// File: rtl/pt_leaf_check.sv
`timescale 1ns/1ps
module pt_leaf_check
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int PTE_W      = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int LVL_W      = 2
) (
  input  logic [PTE_W-1:0]  entry,
  input  logic [LVL_W-1:0]  level,
  output logic              stop,
  output logic [PTE_W-1:0]  result,
  output logic [ADDR_W-1:0] next_base
);
  always_comb begin
    stop   = !entry[PTE_V_BIT] || entry[PTE_LEAF_BIT] || (level == '0);
    result = entry;
    result[PTE_V_BIT] = entry[PTE_V_BIT] & entry[PTE_LEAF_BIT];
    next_base = {entry[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int PTE_W      = 64,
  parameter int LEVELS     = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int PTE_LG     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [PTE_W-1:0]  resp_pte,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_resp_valid,
  input  logic [PTE_W-1:0]  rd_resp_data,
  input  logic              xlate_en,
  input  logic [ADDR_W-1:0] pt_base,
  input  logic [ADDR_W-1:0] mem_size
);
  localparam int LVL_W = $clog2(LEVELS);
  localparam int VPN_W = ADDR_W - PAGE_SHIFT;

  walk_state_t       state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] limit_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [PTE_W-1:0]  res_q;

  logic [ADDR_W-1:0] entry_addr;
  logic              entry_beyond;
  logic [PTE_W-1:0]  ident_pte;
  logic              leaf_stop;
  logic [PTE_W-1:0]  leaf_result;
  logic [ADDR_W-1:0] leaf_next_base;
  logic              unused_base_lo;

  assign unused_base_lo = ^pt_base[PAGE_SHIFT-1:0];

  pt_entry_addr #(
    .ADDR_W(ADDR_W), .LEVELS(LEVELS), .PAGE_SHIFT(PAGE_SHIFT), .PTE_LG(PTE_LG)
  ) u_addr (
    .vpn(vpn_q), .base(base_q), .level(lvl_q), .limit(limit_q),
    .entry_addr(entry_addr), .beyond(entry_beyond)
  );

  pt_identity_pte #(
    .ADDR_W(ADDR_W), .PTE_W(PTE_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_ident (
    .vaddr(req_vaddr), .limit(mem_size), .pte(ident_pte)
  );

  pt_leaf_check #(
    .ADDR_W(ADDR_W), .PTE_W(PTE_W), .PAGE_SHIFT(PAGE_SHIFT), .LVL_W(LVL_W)
  ) u_leaf (
    .entry(rd_resp_data), .level(lvl_q), .stop(leaf_stop),
    .result(leaf_result), .next_base(leaf_next_base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
      lvl_q   <= '0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          vpn_q   <= req_vaddr[ADDR_W-1:PAGE_SHIFT];
          base_q  <= {pt_base[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
          limit_q <= mem_size;
          lvl_q   <= LVL_W'(LEVELS - 1);
          if (xlate_en) begin
            state_q <= ST_READ;
          end else begin
            res_q   <= ident_pte;
            state_q <= ST_DONE;
          end
        end
        ST_READ: begin
          if (entry_beyond) begin
            res_q   <= '0;
            state_q <= ST_DONE;
          end else if (rd_req_ready) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (rd_resp_valid) begin
          if (leaf_stop) begin
            res_q   <= leaf_result;
            state_q <= ST_DONE;
          end else begin
            base_q  <= leaf_next_base;
            lvl_q   <= lvl_q - 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_DONE: if (resp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign resp_valid   = (state_q == ST_DONE);
  assign resp_pte     = res_q;
  assign rd_req_valid = (state_q == ST_READ) && !entry_beyond;
  assign rd_addr      = entry_addr;

  a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_pte)));

  a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);

  a_r8_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_addr < limit_q));

  a_r7_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && rd_resp_valid && !leaf_stop) |=>
      (state_q == ST_READ && lvl_q == $past(lvl_q) - 1'b1));
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  localparam int AW = 48;
  localparam int PW = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic req_valid, req_ready, resp_valid, resp_ready;
  logic [AW-1:0] req_vaddr, rd_addr, pt_base, mem_size;
  logic [PW-1:0] resp_pte, rd_resp_data;
  logic rd_req_valid, rd_req_ready, rd_resp_valid, xlate_en;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_pte(resp_pte),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .xlate_en(xlate_en), .pt_base(pt_base), .mem_size(mem_size)
  );

  logic [PW-1:0] tbl [logic [AW-1:0]];
  logic [AW-1:0] exp_addr [4];
  int exp_n, rd_n;
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] rd_tbl(input logic [AW-1:0] a);
    if (tbl.exists(a)) return tbl[a];
    return '0;
  endfunction

  // Reference walk from the requirements; records the expected read addresses
  function automatic logic [PW-1:0] ref_walk(input logic [AW-1:0] va, input bit en,
                                             input logic [AW-1:0] base, input logic [AW-1:0] msz);
    logic [PW-1:0] e, r;
    logic [AW-1:0] b, a;
    exp_n = 0;
    if (!en) begin
      r = '0;
      r[63:12] = 52'(va[47:12]);
      r[9:4] = 6'h3f;
      r[1] = 1'b1;
      r[0] = (va < msz);
      return r;
    end
    b = {base[47:12], 12'h0};
    for (int lvl = 3; lvl >= 0; lvl--) begin
      a = b + (AW'((va >> (12 + 9*lvl)) & 48'h1ff) << 3);
      if (a >= msz) return '0;
      exp_addr[exp_n] = a;
      exp_n++;
      e = rd_tbl(a);
      if (!e[0] || e[1] || lvl == 0) begin
        r = e;
        r[0] = e[0] & e[1];
        return r;
      end
      b = {e[47:12], 12'h0};
    end
    return '0;
  endfunction

  // Memory responder: random grant delay and latency
  bit pend;
  int lat;
  logic [AW-1:0] paddr;
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_req_ready = 0; rd_resp_valid = 0; rd_resp_data = '0; pend = 0;
    end else begin
      rd_req_ready = 0;
      rd_resp_valid = 0;
      if (pend) begin
        if (lat == 0) begin
          rd_resp_valid = 1;
          rd_resp_data = rd_tbl(paddr);
          pend = 0;
        end else lat--;
      end else if (rd_req_valid && ($urandom % 4 != 0)) begin
        rd_req_ready = 1;
        pend = 1;
        paddr = rd_addr;
        lat = $urandom % 3;
        // R4 R5: read address order and base chaining
        if (rd_n < exp_n) check(rd_addr == exp_addr[rd_n], "R4 R5 read address", 64'(rd_addr), 64'(exp_addr[rd_n]));
        else check(1'b0, "R8 R9 unexpected read", 64'(rd_addr), 64'(rd_n));
        rd_n++;
      end
    end
  end

  task automatic run_walk(input logic [AW-1:0] va, input bit en, input logic [AW-1:0] base,
                          input logic [AW-1:0] msz, input string tag);
    logic [PW-1:0] exp, first;
    exp = ref_walk(va, en, base, msz);
    rd_n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_vaddr = va; xlate_en = en; pt_base = base; mem_size = msz;
    @(negedge clk);
    // R11: scramble the sampled settings during the walk
    req_valid = 0; xlate_en = ~en; pt_base = {$urandom, $urandom}; mem_size = {$urandom, $urandom};
    while (!resp_valid) @(negedge clk);
    first = resp_pte;
    check(resp_pte == exp, tag, resp_pte, exp);
    repeat ($urandom % 3) begin
      @(negedge clk);
      check(resp_valid && resp_pte == first, "R10 result hold", resp_pte, first);
    end
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
    check(rd_n == exp_n, "R7 R9 read count", 64'(rd_n), 64'(exp_n));
  endtask

  task automatic random_trial();
    logic [AW-1:0] va, base, msz, b, a, pages, ppn;
    logic [PW-1:0] e;
    int s, kind;
    bit en;
    msz = 48'h1 << (20 + $urandom % 11);
    pages = msz >> 12;
    base = AW'({$urandom, $urandom}) % msz;
    va = AW'({$urandom, $urandom});
    en = ($urandom % 8) != 0;
    s = $urandom % 4;
    kind = $urandom % 3;
    tbl.delete();
    b = {base[47:12], 12'h0};
    for (int lvl = 3; lvl >= s; lvl--) begin
      a = b + (AW'((va >> (12 + 9*lvl)) & 48'h1ff) << 3);
      e = {$urandom, $urandom};
      if (lvl > s) begin
        ppn = ($urandom % 16 == 0) ? pages + AW'($urandom % 4) : AW'($urandom) % pages;
        e[47:12] = ppn[35:0];
        e[1] = 0; e[0] = 1;
        b = {ppn[35:0], 12'h0};
      end else begin
        if (kind == 0) e[0] = 0;
        else if (kind == 1) begin e[0] = 1; e[1] = 1; end
        else begin e[0] = 1; e[1] = 0; end
      end
      tbl[a] = e;
    end
    run_walk(va, en, base, msz, "R2 R3 R6 R11 random walk result");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] b, a, va;
    logic [PW-1:0] e;
    void'($urandom(32'd20240611));
    rst_n = 0; req_valid = 0; resp_ready = 0; req_vaddr = '0;
    xlate_en = 0; pt_base = '0; mem_size = '0; exp_n = 0; rd_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle state after reset
    check(req_ready && !resp_valid && !rd_req_valid, "R1 reset state",
          64'({req_ready, resp_valid, rd_req_valid}), 64'b100);

    // R2 R3: identity entry at the memory boundary
    run_walk(48'hFFFFFF, 0, '0, 48'h1000000, "R2 R3 identity last byte");
    run_walk(48'h1000000, 0, '0, 48'h1000000, "R3 identity at limit");

    // R8: root already outside memory
    tbl.delete();
    run_walk(48'h123456789, 1, 48'h40000123, 48'h40000000, "R8 root beyond limit");

    // R6: invalid entry at the top level, one read
    tbl.delete();
    run_walk(48'hABCDE000, 1, 48'h10000, 48'h40000000, "R6 invalid at level 3");

    // R7: four valid non-leaf entries
    tbl.delete();
    va = 48'h8040_2010_0abc;
    b = 48'h20000;
    for (int lvl = 3; lvl >= 0; lvl--) begin
      a = b + (AW'((va >> (12 + 9*lvl)) & 48'h1ff) << 3);
      e = '0; e[0] = 1; e[47:12] = 36'h30 + 36'(lvl);
      tbl[a] = e;
      b = {e[47:12], 12'h0};
    end
    run_walk(va, 1, 48'h20fff, 48'h40000000, "R7 non-leaf at level 0");

    // R6: leaf at level 2 with permissions
    tbl.delete();
    va = 48'h0000_7fc0_1234;
    a = 48'h5000 + (AW'((va >> 39) & 48'h1ff) << 3);
    e = '0; e[0] = 1; e[47:12] = 36'h77;
    tbl[a] = e;
    a = 48'h77000 + (AW'((va >> 30) & 48'h1ff) << 3);
    e = 64'hF000_0000_1234_5000; e[9:0] = 10'h2A7;
    tbl[a] = e;
    run_walk(va, 1, 48'h5000, 48'h40000000, "R6 leaf at level 2");

    for (int i = 0; i < 300; i++) random_trial();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule